// File: doc/BRIEF.md
# Column-serial lookup-table multiplier

This block multiplies two 4-bit unsigned operands and forms the 8-bit product one result column per clock. The arithmetic is done by a lookup, not by adder gates. A column counter steers the operand bits through multiplexers. For column k, the multiplier bits are paired with a copy of the multiplicand that is shifted and padded with zeros, so that multiplier bit j meets multiplicand bit k-j, or a zero when that index falls outside 0..3. A small read-only truth table is generated inside the RTL. It takes those bits together with the carry left by the previous column. It returns the column's product bit and the carry for the next column.

Each product bit is shifted into a result register, lowest column first. After eight columns the register holds the full product. A one-cycle done pulse marks the result as ready, and the product stays on the output until the next operation is accepted. The operands are captured when a start request is accepted while the block is idle.

Top module: `colmul_top`

## Requirements
- R1: While reset is asserted, and right after it is released, busy_o and done_o are 0 and prod_o is 0.
- R2: A start_i seen high at a clock edge while the block is idle is accepted. busy_o is 1 from that edge for exactly 8 cycles, one per result column, and is 0 afterwards.
- R3: done_o is 1 for exactly one cycle. That cycle is the one right after the final column step, and in it busy_o is already 0.
- R4: When done_o is 1, prod_o equals op_a_i * op_b_i as an unsigned 8-bit value, using the operands captured at acceptance. This holds for all 256 operand pairs.
- R5: A start_i pulse while busy_o is 1 is ignored. The run in progress keeps its timing and its product.
- R6: The operands are sampled only at acceptance. Changes on op_a_i or op_b_i while busy_o is 1 do not change the result.
- R7: While the block is idle and no start is accepted, prod_o holds its last value, whatever the operand inputs do.
- R8: The carry passed between columns is cleared at acceptance and is zero after the final column, so even the largest product (15*15 = 225) is exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin a multiplication, taken only when idle |
| op_a_i | input | 4 | Multiplicand |
| op_b_i | input | 4 | Multiplier |
| busy_o | output | 1 | High while the column steps run |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| prod_o | output | 8 | Product, built LSB first and held while idle |

## Verification
A corrupted carry or a miscounted column shows up only in prod_o when done_o pulses, nine cycles after acceptance. Checking all operand pairs therefore reaches every truth-table row that can occur and every carry value. A counter that stops early or runs too long moves the done pulse or the falling edge of busy_o, and the bench checks these cycle by cycle. A wrong operand-capture or hold path shows as a product that follows inputs changed during or after a run.

// File: rtl/colmul_pkg.sv
package colmul_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } colmul_state_e;

  // carry width needed so that a column sum of width-many terms plus carry fits
  function automatic int unsigned carry_bits(input int unsigned width);
    return (width < 2) ? 1 : $clog2(width);
  endfunction

endpackage

// File: rtl/colmul_ctrl.sv
module colmul_ctrl
  import colmul_pkg::*;
#(
  parameter int unsigned OP_W = 4,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned CNT_W  = $clog2(PROD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             last_o,
  output logic [CNT_W-1:0] col_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LastCol = CNT_W'(PROD_W - 1);

  colmul_state_e    state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_RUN);
  assign last_o   = step_o && (cnt_q == LastCol);
  assign cnt_en   = accept_o || step_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (accept_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) state_d = ST_IDLE;
    end
    done_d = last_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign col_o  = cnt_q;
  assign done_o = done_q;

  assert_accept_enters_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (step_o && cnt_q == '0));
  assert_run_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !last_o) |=> step_o);
  assert_run_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !step_o);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !step_o);

endmodule

// File: rtl/colmul_steer.sv
module colmul_steer #(
  parameter int unsigned OP_W = 4,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned CNT_W  = $clog2(PROD_W),
  localparam int unsigned EXT_W  = 3 * OP_W - 1
) (
  input  logic [CNT_W-1:0] col_i,
  input  logic [OP_W-1:0]  a_i,
  output logic [OP_W-1:0]  a_col_o
);

  // multiplicand padded with zeros on both sides; lane j picks bit col-j
  logic [EXT_W-1:0] ext;
  assign ext = {{OP_W{1'b0}}, a_i, {(OP_W-1){1'b0}}};

  for (genvar j = 0; j < OP_W; j++) begin : g_lane
    always_comb begin
      a_col_o[j] = ext[int'(col_i) + (OP_W - 1 - j)];
    end
  end

endmodule

// File: rtl/colmul_lut.sv
module colmul_lut #(
  parameter int unsigned OP_W    = 4,
  parameter int unsigned CARRY_W = 2,
  localparam int unsigned AW     = CARRY_W + 2 * OP_W,
  localparam int unsigned DW     = 1 + CARRY_W,
  localparam int unsigned DEPTH  = 1 << AW
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);

  // address layout: {carry, aligned multiplicand lanes, multiplier}
  function automatic logic [DW-1:0] entry(input logic [AW-1:0] e);
    logic [OP_W-1:0]    bb;
    logic [OP_W-1:0]    aa;
    logic [CARRY_W-1:0] cc;
    int unsigned        sum;
    bb  = e[OP_W-1:0];
    aa  = e[2*OP_W-1:OP_W];
    cc  = e[AW-1:2*OP_W];
    sum = int'(cc);
    for (int i = 0; i < OP_W; i++) sum += int'(aa[i] & bb[i]);
    return DW'(sum);
  endfunction

  logic [DW-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_rom
    assign rom[e] = entry(AW'(e));
  end

  assign data_o = rom[addr_i];

endmodule

// File: rtl/colmul_accum.sv
module colmul_accum #(
  parameter int unsigned OP_W    = 4,
  parameter int unsigned CARRY_W = 2,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned DW     = 1 + CARRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic               last_i,
  input  logic [DW-1:0]      lut_i,
  output logic [CARRY_W-1:0] carry_o,
  output logic [PROD_W-1:0]  prod_o
);

  logic [CARRY_W-1:0] carry_q, carry_d;
  logic [PROD_W-1:0]  prod_q, prod_d;
  logic               carry_en;

  assign carry_en = clear_i || step_i;

  always_comb begin
    carry_d = clear_i ? '0 : lut_i[DW-1:1];
    prod_d  = {lut_i[0], prod_q[PROD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= '0;
      prod_q  <= '0;
    end else begin
      if (carry_en) carry_q <= carry_d;
      if (step_i)   prod_q  <= prod_d;
    end
  end

  assign carry_o = carry_q;
  assign prod_o  = prod_q;

  assert_carry_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (carry_q == '0));
  assert_carry_flushed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_i) |=> (carry_q == '0));
  assert_prod_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(prod_q));

endmodule

// File: rtl/colmul_top.sv
module colmul_top
  import colmul_pkg::*;
#(
  parameter int unsigned OP_W = 4,
  localparam int unsigned PROD_W  = 2 * OP_W,
  localparam int unsigned CNT_W   = $clog2(PROD_W),
  localparam int unsigned CARRY_W = carry_bits(OP_W),
  localparam int unsigned AW      = CARRY_W + 2 * OP_W,
  localparam int unsigned DW      = 1 + CARRY_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PROD_W-1:0] prod_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic               accept, step, last;
  logic [CNT_W-1:0]   col;
  logic [OP_W-1:0]    a_q, b_q, a_d, b_d;
  logic [OP_W-1:0]    a_col;
  logic [CARRY_W-1:0] carry;
  logic [DW-1:0]      lut_data;

  colmul_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .last_o   (last),
    .col_o    (col),
    .done_o   (done_o)
  );

  always_comb begin
    a_d = op_a_i;
    b_d = op_b_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  colmul_steer #(.OP_W(OP_W)) steer_i (
    .col_i   (col),
    .a_i     (a_q),
    .a_col_o (a_col)
  );

  colmul_lut #(.OP_W(OP_W), .CARRY_W(CARRY_W)) lut_i (
    .addr_i ({carry, a_col, b_q}),
    .data_o (lut_data)
  );

  colmul_accum #(.OP_W(OP_W), .CARRY_W(CARRY_W)) accum_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .step_i  (step),
    .last_i  (last),
    .lut_i   (lut_data),
    .carry_o (carry),
    .prod_o  (prod_o)
  );

  assign busy_o = step;

  assert_ops_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(a_q) && $stable(b_q)));
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last) |=> busy_o);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy_o && !done_o && prod_o == '0));

endmodule

// File: tb/colmul_top_tb_top.sv
module colmul_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [3:0] op_a_i, op_b_i;
  logic       busy_o, done_o;
  logic [7:0] prod_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  colmul_top dut_i (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .prod_o  (prod_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 start pulse mid-run (R5), 2 operands changed mid-run (R6)
  task automatic run_op(input logic [3:0] a, input logic [3:0] b, input int mode,
                        input bit verbose);
    @(negedge clk);
    op_a_i  = a;
    op_b_i  = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (verbose) begin
      chk("R2 busy after accept", int'(busy_o), 1);
      chk("R3 no early done", int'(done_o), 0);
    end
    for (int i = 1; i < 8; i++) begin
      if (mode == 1 && i == 3) begin start_i = 1'b1; op_a_i = ~a; op_b_i = ~b; end
      if (mode == 1 && i == 4) start_i = 1'b0;
      if (mode == 2) begin op_a_i = 4'(i * 5); op_b_i = 4'(i * 3 + 1); end
      @(negedge clk);
      if (verbose) chk(mode == 1 ? "R5 busy kept" : "R2 busy column", int'(busy_o), 1);
    end
    @(negedge clk);
    if (verbose) begin
      chk("R2 busy low after 8 columns", int'(busy_o), 0);
      chk("R3 done pulse", int'(done_o), 1);
    end
    chk(mode == 1 ? "R5 product" : (mode == 2 ? "R6 product" : "R4 product"),
        int'(prod_o), int'(a) * int'(b));
    @(negedge clk);
    if (verbose) begin
      chk("R3 done single cycle", int'(done_o), 0);
      chk("R7 product held", int'(prod_o), int'(a) * int'(b));
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 1'b0; op_a_i = '0; op_b_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 prod in reset", int'(prod_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after release", int'(busy_o), 0);
    chk("R1 prod after release", int'(prod_o), 0);
  endtask

  task automatic t_hold();
    run_op(4'd9, 4'd7, 0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      op_a_i = 4'(i); op_b_i = 4'(15 - i);
      @(negedge clk);
    end
    chk("R7 idle hold", int'(prod_o), 63);
    chk("R7 no busy while idle", int'(busy_o), 0);
  endtask

  task automatic t_corners();
    run_op(4'd15, 4'd15, 0, 1'b1);   // R8 largest carry chain
    run_op(4'd0, 4'd0, 0, 1'b1);     // R8 after maximal carry, must be zero
    run_op(4'd15, 4'd1, 0, 1'b1);
    run_op(4'd1, 4'd15, 0, 1'b1);
    run_op(4'd8, 4'd8, 0, 1'b1);
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(4'(a), 4'(b), 0, 1'b0);   // R4
  endtask

  initial begin
    t_reset();
    t_corners();
    run_op(4'd13, 4'd11, 1, 1'b1);       // R5
    run_op(4'd6, 4'd14, 2, 1'b1);        // R6
    t_hold();
    t_exhaustive();
    summary();
  end

endmodule